// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block sits between an 8-bit controller core and its external program and data memories. The core hands it one request at a time: a code fetch, a data read or a data write, with a 16-bit address and, for writes, a byte of write data. The sequencer runs one machine cycle of twelve oscillator periods per access, and returns the read byte together with a one-cycle completion pulse.

On the pin side, the low address byte and the data byte share one 8-bit port. The low address goes out first while the latch strobe is high, so that an external latch can hold it. After the strobe falls, the same port carries data. The high address byte has a port of its own. Separate active-low strobes select program memory reads, data memory reads and data memory writes.

Code fetches are steered. When the internal-ROM enable input is high, a fetch at an address within the internal ROM range is served from the on-chip ROM port and leaves the external pins idle. A fetch above that range, or any fetch while the enable is low, goes to the external bus. Data accesses always use the external bus.

Top module: `xbus_seq`

## Requirements
- R1: After reset, `ale` is low, `psen_n`, `rd_n` and `wr_n` are high, `ad_oe`, `busy` and `done` are low.
- R2: An external access starts with two oscillator periods (ticks 0 and 1 after acceptance) in which `ale` is high, `ad_oe` is high and `ad_out` carries address bits 7:0. `ale` is low for ticks 2 to 11.
- R3: During all twelve ticks of an external access, `addr_hi` carries address bits 15:8.
- R4: An external code fetch (`req_kind` = 0) holds `psen_n` low for ticks 2 to 11 with `ad_oe` low. The value on `ad_in` in tick 11 is returned on `rdata` in the cycle where `done` is high.
- R5: A data read (`req_kind` = 1) uses `rd_n` with the same ticks, tri-state and sampling point as R4.
- R6: A data write (`req_kind` = 2) holds `wr_n` low for ticks 2 to 11, with `ad_oe` high and `ad_out` equal to the write data.
- R7: At most one of `psen_n`, `rd_n` and `wr_n` is low at any time, and all three are high while the block is idle.
- R8: A code fetch at an address of 0FFFh or lower, with `int_rom_en` high, is internal. `rom_en` is high and `rom_addr` carries address bits 11:0 for twelve ticks. `ale` stays low and all strobes stay high. `rdata` returns `rom_rdata` as sampled in tick 11.
- R9: With `int_rom_en` high, a code fetch at 1000h or above goes to the external bus.
- R10: With `int_rom_en` low, every code fetch goes to the external bus, including address 0000h.
- R11: `busy` is high for the twelve ticks of an access. `done` is high for exactly one cycle, the one after tick 11. A request that arrives while `busy` is high is ignored.
- R12: Data reads and writes go to the external bus whatever their address and whatever `int_rom_en` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one period per tick |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_kind | input | 2 | 0 code fetch, 1 data read, 2 data write |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| int_rom_en | input | 1 | High: low code addresses come from internal ROM |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read result, valid with `done` |
| rom_en | output | 1 | Internal ROM access in progress |
| rom_addr | output | 12 | Internal ROM address |
| rom_rdata | input | 8 | Internal ROM data |
| ad_out | output | 8 | Shared port, driven value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port, received value |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program memory read strobe, active low |
| rd_n | output | 1 | Data memory read strobe, active low |
| wr_n | output | 1 | Data memory write strobe, active low |

## Verification
The bench drives fetches on both sides of the 0FFFh/1000h boundary with the ROM enable high, and a fetch at 0000h with it low. These tell apart a router that compares the address correctly, one that is off by one, and one that ignores the enable. Data reads and writes at low addresses with the enable high show that only fetches are steered. A write followed by a read of the same location shows that the latched low address and the write data reach the memory model. A request raised in the middle of an access checks that nothing is queued or restarted. Every tick of every access is compared against the expected pin pattern, so a strobe that is one tick early or late is caught, and so is a strobe of the wrong kind.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    parameter int XB_ADDR_W = 16;
    parameter int XB_DATA_W = 8;
    localparam int XB_HI_W  = XB_ADDR_W - XB_DATA_W;

    typedef enum logic [1:0] {
        XK_FETCH  = 2'd0,
        XK_DREAD  = 2'd1,
        XK_DWRITE = 2'd2,
        XK_NONE   = 2'd3
    } xk_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } xb_phase_e;

    typedef struct packed {
        xk_kind_e               kind;
        logic [XB_ADDR_W-1:0]   addr;
        logic [XB_DATA_W-1:0]   wdata;
        logic                   internal;
    } xbus_req_t;

    typedef struct packed {
        logic                 ale;
        logic                 psen_n;
        logic                 rd_n;
        logic                 wr_n;
        logic                 ad_oe;
        logic [XB_DATA_W-1:0] ad_out;
        logic [XB_HI_W-1:0]   addr_hi;
    } xbus_pins_t;

    localparam xbus_pins_t XB_PINS_IDLE = '{
        ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
        ad_oe: 1'b0, ad_out: '0, addr_hi: '0
    };

    // A fetch is internal only when the ROM is enabled and the address is in range.
    function automatic logic fetch_is_internal(
        input xk_kind_e             kind,
        input logic [XB_ADDR_W-1:0] addr,
        input logic                 rom_on,
        input logic [XB_ADDR_W-1:0] rom_last
    );
        return (kind == XK_FETCH) && rom_on && (addr <= rom_last);
    endfunction

endpackage

// File: rtl/xbus_route.sv
module xbus_route
    import xbus_pkg::*;
#(
    parameter logic [XB_ADDR_W-1:0] ROM_LAST = 16'h0FFF
) (
    input  xk_kind_e             kind,
    input  logic [XB_ADDR_W-1:0] addr,
    input  logic                 rom_on,
    output logic                 internal
);
    always_comb begin
        internal = fetch_is_internal(kind, addr, rom_on, ROM_LAST);
    end
endmodule

// File: rtl/xbus_timer.sv
module xbus_timer
    import xbus_pkg::*;
#(
    parameter int OSC_PER_STATE    = 2,
    parameter int STATES_PER_CYCLE = 6,
    parameter int ADDR_STATES      = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output logic      active,
    output logic      last,
    output xb_phase_e phase
);
    localparam int TOTAL      = OSC_PER_STATE * STATES_PER_CYCLE;
    localparam int ADDR_TICKS = OSC_PER_STATE * ADDR_STATES;
    localparam int TICK_W     = (TOTAL > 1) ? $clog2(TOTAL) : 1;
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TOTAL - 1);
    localparam logic [TICK_W-1:0] ADDR_END  = TICK_W'(ADDR_TICKS);

    logic [TICK_W-1:0] tick_q;
    logic              act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            tick_q <= '0;
        end else if (!act_q) begin
            if (start) begin
                act_q  <= 1'b1;
                tick_q <= '0;
            end
        end else if (tick_q == LAST_TICK) begin
            act_q  <= 1'b0;
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    always_comb begin
        active = act_q;
        last   = act_q && (tick_q == LAST_TICK);
        if (!act_q)                phase = PH_IDLE;
        else if (tick_q < ADDR_END) phase = PH_ADDR;
        else                        phase = PH_DATA;
    end
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
    import xbus_pkg::*;
(
    input  xbus_req_t  cur,
    input  xb_phase_e  phase,
    output xbus_pins_t pins
);
    logic ext_on;

    always_comb begin
        ext_on = (phase != PH_IDLE) && !cur.internal;
        pins   = XB_PINS_IDLE;
        if (ext_on) begin
            pins.addr_hi = cur.addr[XB_ADDR_W-1:XB_DATA_W];
            if (phase == PH_ADDR) begin
                pins.ale    = 1'b1;
                pins.ad_oe  = 1'b1;
                pins.ad_out = cur.addr[XB_DATA_W-1:0];
            end else begin
                unique case (cur.kind)
                    XK_FETCH:  pins.psen_n = 1'b0;
                    XK_DREAD:  pins.rd_n   = 1'b0;
                    XK_DWRITE: begin
                        pins.wr_n   = 1'b0;
                        pins.ad_oe  = 1'b1;
                        pins.ad_out = cur.wdata;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int OSC_PER_STATE    = 2,
    parameter int STATES_PER_CYCLE = 6,
    parameter int ADDR_STATES      = 1,
    parameter int INT_ROM_LAST     = 16'h0FFF,
    localparam int ROM_AW          = $clog2(INT_ROM_LAST + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic [XB_ADDR_W-1:0] req_addr,
    input  logic [XB_DATA_W-1:0] req_wdata,
    input  logic                 int_rom_en,
    output logic                 busy,
    output logic                 done,
    output logic [XB_DATA_W-1:0] rdata,
    output logic                 rom_en,
    output logic [ROM_AW-1:0]    rom_addr,
    input  logic [XB_DATA_W-1:0] rom_rdata,
    output logic [XB_DATA_W-1:0] ad_out,
    output logic                 ad_oe,
    input  logic [XB_DATA_W-1:0] ad_in,
    output logic [XB_HI_W-1:0]   addr_hi,
    output logic                 ale,
    output logic                 psen_n,
    output logic                 rd_n,
    output logic                 wr_n
);
    xbus_req_t  cur_q;
    xk_kind_e   in_kind;
    logic       in_internal;
    logic       accept;
    logic       t_active;
    logic       t_last;
    xb_phase_e  t_phase;
    xbus_pins_t pins;
    logic       done_q;
    logic [XB_DATA_W-1:0] rdata_q;

    assign in_kind = xk_kind_e'(req_kind);
    assign accept  = req_valid && !t_active;

    xbus_route #(
        .ROM_LAST (XB_ADDR_W'(INT_ROM_LAST))
    ) route_i (
        .kind     (in_kind),
        .addr     (req_addr),
        .rom_on   (int_rom_en),
        .internal (in_internal)
    );

    xbus_timer #(
        .OSC_PER_STATE    (OSC_PER_STATE),
        .STATES_PER_CYCLE (STATES_PER_CYCLE),
        .ADDR_STATES      (ADDR_STATES)
    ) timer_i (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .active (t_active),
        .last   (t_last),
        .phase  (t_phase)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{kind: XK_NONE, addr: '0, wdata: '0, internal: 1'b0};
        end else if (accept) begin
            cur_q <= '{kind: in_kind, addr: req_addr, wdata: req_wdata,
                       internal: in_internal};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= t_last;
            if (t_last) begin
                rdata_q <= cur_q.internal ? rom_rdata : ad_in;
            end
        end
    end

    xbus_pins pins_i (
        .cur   (cur_q),
        .phase (t_phase),
        .pins  (pins)
    );

    always_comb begin
        busy     = t_active;
        done     = done_q;
        rdata    = rdata_q;
        rom_en   = t_active && cur_q.internal;
        rom_addr = rom_en ? cur_q.addr[ROM_AW-1:0] : '0;
        ale      = pins.ale;
        psen_n   = pins.psen_n;
        rd_n     = pins.rd_n;
        wr_n     = pins.wr_n;
        ad_oe    = pins.ad_oe;
        ad_out   = pins.ad_out;
        addr_hi  = pins.addr_hi;
    end
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       rom_en,
    input logic       ad_oe,
    input logic [7:0] addr_hi,
    input logic       ale,
    input logic       psen_n,
    input logic       rd_n,
    input logic       wr_n
);
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (psen_n && rd_n && wr_n && !ale));

    a_r2_ale_before_strobe: assert property (@(posedge clk) disable iff (rst)
        ale |-> (psen_n && rd_n && wr_n && ad_oe));

    a_r4_read_floats: assert property (@(posedge clk) disable iff (rst)
        (!psen_n || !rd_n) |-> !ad_oe);

    a_r6_write_drives: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);

    a_r3_hi_steady: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !rom_en) |-> $stable(addr_hi));

    a_r8_internal_no_pins: assert property (@(posedge clk) disable iff (rst)
        rom_en |-> (!ale && psen_n && rd_n && wr_n));

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
endmodule

bind xbus_seq xbus_seq_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .rom_en  (rom_en),
    .ad_oe   (ad_oe),
    .addr_hi (addr_hi),
    .ale     (ale),
    .psen_n  (psen_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n)
);

// File: tb/xbus_seq_tb.sv
module xbus_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        int_rom_en;
    logic        busy, done;
    logic [7:0]  rdata;
    logic        rom_en;
    logic [11:0] rom_addr;
    logic [7:0]  rom_rdata;
    logic [7:0]  ad_out, ad_in, addr_hi;
    logic        ad_oe, ale, psen_n, rd_n, wr_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    xbus_seq dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .int_rom_en(int_rom_en),
        .busy(busy), .done(done), .rdata(rdata), .rom_en(rom_en),
        .rom_addr(rom_addr), .rom_rdata(rom_rdata), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi), .ale(ale),
        .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    // Memory models: external latch, code memory, data memory, internal ROM.
    logic [7:0] lat_lo = 8'h00;
    logic [7:0] dmem [256];

    function automatic logic [7:0] code_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction
    function automatic logic [7:0] rom_val(input logic [11:0] a);
        return {a[11:8], 4'h0} ^ a[7:0] ^ 8'h3C;
    endfunction

    always @(posedge clk) begin
        if (ale) lat_lo <= ad_out;
        if (!wr_n) dmem[lat_lo] <= ad_out;
    end

    assign ad_in = !psen_n ? code_val({addr_hi, lat_lo}) :
                   !rd_n   ? dmem[lat_lo] : 8'h00;
    assign rom_rdata = rom_val(rom_addr);

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic run_access(input logic [1:0] kind, input logic [15:0] addr,
                              input logic [7:0] wd, input logic rom_on,
                              input logic exp_int, input logic [7:0] exp_rd,
                              input string tag, input bit poke);
        @(negedge clk);
        req_valid  = 1'b1;
        req_kind   = kind;
        req_addr   = addr;
        req_wdata  = wd;
        int_rom_en = rom_on;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t < 12; t++) begin
            chk(busy == 1'b1, $sformatf("R11 %s busy t%0d", tag, t), busy, 1);
            chk(done == 1'b0, $sformatf("R11 %s done early t%0d", tag, t), done, 0);
            if (exp_int) begin
                chk(ale == 1'b0 && psen_n && rd_n && wr_n,
                    $sformatf("R8 %s pins quiet t%0d", tag, t),
                    {ale, psen_n, rd_n, wr_n}, 4'b0111);
                chk(rom_en && rom_addr == addr[11:0],
                    $sformatf("R8 %s rom addr t%0d", tag, t), rom_addr, addr[11:0]);
            end else begin
                chk(addr_hi == addr[15:8], $sformatf("R3 %s addr_hi t%0d", tag, t),
                    addr_hi, addr[15:8]);
                chk(ale == (t < 2), $sformatf("R2 %s ale t%0d", tag, t), ale, t < 2);
                if (t < 2) begin
                    chk(ad_oe && ad_out == addr[7:0],
                        $sformatf("R2 %s low addr t%0d", tag, t), ad_out, addr[7:0]);
                    chk(psen_n && rd_n && wr_n, $sformatf("R7 %s strobes t%0d", tag, t),
                        {psen_n, rd_n, wr_n}, 3'b111);
                end else begin
                    chk({psen_n, rd_n, wr_n} ==
                        {kind != 2'd0, kind != 2'd1, kind != 2'd2},
                        $sformatf("R4/R5/R6 %s strobes t%0d", tag, t),
                        {psen_n, rd_n, wr_n},
                        {kind != 2'd0, kind != 2'd1, kind != 2'd2});
                    chk(ad_oe == (kind == 2'd2), $sformatf("R4 %s ad_oe t%0d", tag, t),
                        ad_oe, kind == 2'd2);
                    if (kind == 2'd2)
                        chk(ad_out == wd, $sformatf("R6 %s wdata t%0d", tag, t), ad_out, wd);
                end
            end
            if (poke && t == 5) begin
                req_valid = 1'b1;
                req_kind  = 2'd2;
                req_addr  = 16'h00EE;
                req_wdata = 8'h77;
            end
            if (poke && t == 6) req_valid = 1'b0;
            @(negedge clk);
        end
        chk(done == 1'b1, $sformatf("R11 %s done", tag), done, 1);
        chk(busy == 1'b0, $sformatf("R11 %s busy clear", tag), busy, 0);
        if (kind != 2'd2)
            chk(rdata == exp_rd, $sformatf("R4 %s rdata", tag), rdata, exp_rd);
        @(negedge clk);
        chk(done == 1'b0, $sformatf("R11 %s done single", tag), done, 0);
        chk(psen_n && rd_n && wr_n && !ale, $sformatf("R7 %s idle", tag),
            {ale, psen_n, rd_n, wr_n}, 4'b0111);
    endtask

    task automatic t_reset;
        chk(!ale && psen_n && rd_n && wr_n, "R1 strobes", {ale, psen_n, rd_n, wr_n}, 4'b0111);
        chk(!ad_oe && !busy && !done, "R1 oe/busy/done", {ad_oe, busy, done}, 0);
    endtask

    task automatic t_fetch_boundary;
        run_access(2'd0, 16'h0FFF, 8'h00, 1'b1, 1'b1, rom_val(12'hFFF), "R8 int 0FFF", 1'b0);
        run_access(2'd0, 16'h0000, 8'h00, 1'b1, 1'b1, rom_val(12'h000), "R8 int 0000", 1'b0);
        run_access(2'd0, 16'h1000, 8'h00, 1'b1, 1'b0, code_val(16'h1000), "R9 ext 1000", 1'b0);
        run_access(2'd0, 16'hC35A, 8'h00, 1'b1, 1'b0, code_val(16'hC35A), "R9 ext C35A", 1'b0);
    endtask

    task automatic t_rom_disabled;
        run_access(2'd0, 16'h0000, 8'h00, 1'b0, 1'b0, code_val(16'h0000), "R10 ext 0000", 1'b0);
        run_access(2'd0, 16'h0ABC, 8'h00, 1'b0, 1'b0, code_val(16'h0ABC), "R10 ext 0ABC", 1'b0);
    endtask

    task automatic t_data;
        run_access(2'd1, 16'h0010, 8'h00, 1'b1, 1'b0, 8'h31, "R12 R5 read 0010", 1'b0);
        run_access(2'd2, 16'h0042, 8'h9E, 1'b1, 1'b0, 8'h00, "R12 R6 write 0042", 1'b0);
        run_access(2'd1, 16'h0042, 8'h00, 1'b1, 1'b0, 8'h9E, "R5 readback 0042", 1'b0);
    endtask

    task automatic t_busy_ignore;
        run_access(2'd1, 16'h0020, 8'h00, 1'b0, 1'b0, 8'h61, "R11 poke read", 1'b1);
        chk(busy == 1'b0, "R11 no queued access", busy, 0);
        run_access(2'd1, 16'h00EE, 8'h00, 1'b0, 1'b0, 8'hCB, "R11 poke target untouched", 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = 8'(i * 3 + 1);
        rst = 1'b1; req_valid = 1'b0; req_kind = 2'd0; req_addr = '0;
        req_wdata = '0; int_rom_en = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fetch_boundary();
        t_rom_disabled();
        t_data();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule